// File: doc/BRIEF.md
# Lowest-Pending Interrupt Channel Selector

This block collects the suspend, transfer-complete and transfer-error interrupt flags of a 16-channel DMA controller. It presents them through one 16-bit status register on a simple register bus. Each flag is set by a one-cycle event pulse from its channel. The flag then stays set until software clears it by writing a one to the matching bit. The register also shows three status levels of the selected channel: pending, busy and fetch-error.

The selected channel number is held in a register rather than recomputed every cycle. When the first flag appears, or when a channel below the held number becomes pending, the number moves to the lowest newly pending channel. After software clears flags, it is recomputed as the lowest channel that still has any flag set. Software may also write a channel number to look at that channel, and to clear its flags, indirectly. An aggregated interrupt output is high while any flag of any channel is set.

Top module: `irq_lowest_sel`

## Requirements
- R1: After reset, a read of the register at address 0x20 returns 0x0000 and `irq_any` is low.
- R2: Read data layout at address 0x20: bit 15 pending level, bit 14 busy level, bit 13 fetch-error level, bit 10 suspend flag, bit 9 transfer-complete flag, bit 8 transfer-error flag, bits 3:0 channel number. Bits 12:11 and 7:4 always read 0.
- R3: Bits 15:13 show the levels of the channel held in the channel number field. Writing to these bits has no effect.
- R4: A pulse on `set_susp`, `set_cmpl` or `set_err` for a channel sets that channel's flag. The flag reads back in bit 10, 9 or 8 while that channel is selected.
- R5: A write with bit 10, 9 or 8 at 1 clears that flag of the channel given by the written bits 3:0. Bits written as 0 leave their flags unchanged, and flags of other channels are untouched.
- R6: If a set pulse and a write-one clear hit the same flag in the same cycle, the flag stays set.
- R7: When a channel becomes pending (any of its three flags goes from none set to set), the held number moves to it in two cases: no channel was pending before, or its number is lower than the held number. Several new channels at once choose the lowest.
- R8: A channel with a number above the held one that becomes pending does not change the held number.
- R9: After a write with any of bits 10:8 at 1, the held number becomes the lowest channel that still has any flag set.
- R10: While no channel has any flag set, bits 3:0 read as 0.
- R11: A write with bits 10:8 all 0 stores bits 3:0 as the selected channel. Later reads show that channel's levels and flags.
- R12: `irq_any` is high exactly while at least one flag of any channel is set.
- R13: `bus_ready` is high in every cycle with `bus_rd` or `bus_wr`. Reads of any other address return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| set_susp | input | 16 | Per-channel suspend event pulse |
| set_cmpl | input | 16 | Per-channel transfer-complete event pulse |
| set_err | input | 16 | Per-channel transfer-error event pulse |
| ch_pend | input | 16 | Per-channel pending level |
| ch_busy | input | 16 | Per-channel busy level |
| ch_ferr | input | 16 | Per-channel invalid-descriptor fetch level |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| bus_ready | output | 1 | Access accepted this cycle |
| irq_any | output | 1 | Any flag of any channel set |

## Verification
The assertions assume three things about the inputs. Set pulses are clean levels sampled at the clock. Read and write strobes are never both high in the same cycle. Reset holds the event inputs low. The bench meets these assumptions by driving every input at the falling edge, by never issuing a read and a write together, and by keeping all pulses at zero until reset is released. One case steers a set pulse and a clearing write into the same cycle on purpose, so that the set-wins rule is exercised inside these assumptions.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int BIT_PEND  = 15;
    localparam int BIT_BUSY  = 14;
    localparam int BIT_FERR  = 13;
    localparam int BIT_SUSP  = 10;
    localparam int BIT_CMPL  = 9;
    localparam int BIT_ERR   = 8;
    localparam int ID_BITS   = 4;
    localparam logic [15:0] USED_MASK = 16'hE70F;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_s,
    input  logic [NCH-1:0] set_c,
    input  logic [NCH-1:0] set_e,
    input  logic [NCH-1:0] clr_s,
    input  logic [NCH-1:0] clr_c,
    input  logic [NCH-1:0] clr_e,
    output logic [NCH-1:0] fl_s_q,
    output logic [NCH-1:0] fl_c_q,
    output logic [NCH-1:0] fl_e_q,
    output logic [NCH-1:0] any_d
);
    typedef struct packed {
        logic [NCH-1:0] s;
        logic [NCH-1:0] c;
        logic [NCH-1:0] e;
    } flags_t;

    flags_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        // a set event on the same cycle overrides a clear
        st_d.s = (st_q.s & ~clr_s) | set_s;
        st_d.c = (st_q.c & ~clr_c) | set_c;
        st_d.e = (st_q.e & ~clr_e) | set_e;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fl_s_q = st_q.s;
    assign fl_c_q = st_q.c;
    assign fl_e_q = st_q.e;
    assign any_d  = st_d.s | st_d.c | st_d.e;

    // R6: every pulsed flag is set one cycle later, clear or not
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_s | set_c | set_e)) |=>
        (((fl_s_q & $past(set_s)) == $past(set_s)) &&
         ((fl_c_q & $past(set_c)) == $past(set_c)) &&
         ((fl_e_q & $past(set_e)) == $past(set_e))))
        else $error("set event lost");

    // R5: a flag can only fall where a clear was requested
    p_clear_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=>
        ((($past(fl_s_q) & ~fl_s_q) & ~$past(clr_s)) == '0) &&
        ((($past(fl_c_q) & ~fl_c_q) & ~$past(clr_c)) == '0) &&
        ((($past(fl_e_q) & ~fl_e_q) & ~$past(clr_e)) == '0))
        else $error("flag dropped without clear");
endmodule

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
    parameter int NCH = 16,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] vec,
    output logic [IW-1:0]  idx,
    output logic           found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_lowest_sel.sv
module irq_lowest_sel
    import irq_sel_pkg::*;
#(
    parameter int          NCH      = 16,
    parameter int          AW       = 8,
    parameter int          DW       = 16,
    parameter logic [7:0]  REG_ADDR = 8'h20,
    localparam int         IW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_susp,
    input  logic [NCH-1:0] set_cmpl,
    input  logic [NCH-1:0] set_err,
    input  logic [NCH-1:0] ch_pend,
    input  logic [NCH-1:0] ch_busy,
    input  logic [NCH-1:0] ch_ferr,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_ready,
    output logic           irq_any
);
    typedef struct packed {
        logic [IW-1:0] id;
    } sel_t;

    sel_t sel_d, sel_q;

    logic           hit, wr_hit, rd_hit, clr_req;
    logic [IW-1:0]  wr_id, tgt_id;
    logic [NCH-1:0] tgt_1h, clr_s, clr_c, clr_e;
    logic [NCH-1:0] fl_s, fl_c, fl_e, any_q, any_nx, rose;
    logic [IW-1:0]  low_nx, low_rose;
    logic           nx_found, rose_found;

    assign hit     = (bus_addr == AW'(REG_ADDR));
    assign wr_hit  = bus_wr & hit;
    assign rd_hit  = bus_rd & hit;
    assign wr_id   = bus_wdata[IW-1:0];
    assign clr_req = wr_hit & (bus_wdata[BIT_SUSP] | bus_wdata[BIT_CMPL] | bus_wdata[BIT_ERR]);
    assign tgt_id  = wr_hit ? wr_id : sel_q.id;

    always_comb begin
        tgt_1h = '0;
        tgt_1h[tgt_id] = 1'b1;
    end

    assign clr_s = tgt_1h & {NCH{wr_hit & bus_wdata[BIT_SUSP]}};
    assign clr_c = tgt_1h & {NCH{wr_hit & bus_wdata[BIT_CMPL]}};
    assign clr_e = tgt_1h & {NCH{wr_hit & bus_wdata[BIT_ERR]}};

    irq_flag_bank #(.NCH(NCH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_s  (set_susp),
        .set_c  (set_cmpl),
        .set_e  (set_err),
        .clr_s  (clr_s),
        .clr_c  (clr_c),
        .clr_e  (clr_e),
        .fl_s_q (fl_s),
        .fl_c_q (fl_c),
        .fl_e_q (fl_e),
        .any_d  (any_nx)
    );

    assign any_q = fl_s | fl_c | fl_e;
    assign rose  = any_nx & ~any_q;

    irq_lowest_find #(.NCH(NCH)) u_find_nx (
        .vec   (any_nx),
        .idx   (low_nx),
        .found (nx_found)
    );

    irq_lowest_find #(.NCH(NCH)) u_find_rose (
        .vec   (rose),
        .idx   (low_rose),
        .found (rose_found)
    );

    always_comb begin
        sel_d = sel_q;
        if (clr_req) begin
            sel_d.id = nx_found ? low_nx : '0;
        end else if (wr_hit) begin
            sel_d.id = wr_id;
        end else if (rose_found) begin
            if (!(|any_q) || (low_rose < sel_q.id)) sel_d.id = low_rose;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign irq_any   = |any_q;
    assign bus_ready = bus_rd | bus_wr;

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[BIT_PEND]     = ch_pend[sel_q.id];
            bus_rdata[BIT_BUSY]     = ch_busy[sel_q.id];
            bus_rdata[BIT_FERR]     = ch_ferr[sel_q.id];
            bus_rdata[BIT_SUSP]     = fl_s[sel_q.id];
            bus_rdata[BIT_CMPL]     = fl_c[sel_q.id];
            bus_rdata[BIT_ERR]      = fl_e[sel_q.id];
            bus_rdata[IW-1:0]       = irq_any ? sel_q.id : '0;
        end
    end

    // R2: reserved bits never carry data
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ((bus_rdata & ~DW'(USED_MASK)) == '0))
        else $error("reserved bit set");

    // R10: empty flag bank shows channel number zero
    p_empty_id_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && (fl_s == '0) && (fl_c == '0) && (fl_e == '0)) |-> (bus_rdata[IW-1:0] == '0))
        else $error("id nonzero with nothing pending");

    // R13: foreign reads are acknowledged and empty
    p_foreign_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> (bus_ready && (bus_rdata == '0)))
        else $error("foreign read returned data");

    // R8: a rising channel above a pending selection never moves it
    p_higher_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && rose_found && irq_any && (low_rose > sel_q.id)) |=> $stable(sel_q.id))
        else $error("higher channel moved id");
endmodule

// File: tb/irq_lowest_sel_tb_top.sv
module irq_lowest_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] set_susp = '0, set_cmpl = '0, set_err = '0;
    logic [15:0] ch_pend = '0, ch_busy = '0, ch_ferr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h20;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ready, irq_any;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_lowest_sel dut_i (
        .clk(clk), .rst_n(rst_n),
        .set_susp(set_susp), .set_cmpl(set_cmpl), .set_err(set_err),
        .ch_pend(ch_pend), .ch_busy(ch_busy), .ch_ferr(ch_ferr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq_any(irq_any)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [15:0] d, output logic rdy);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        d = bus_rdata; rdy = bus_ready;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // kind: 0 suspend, 1 complete, 2 error
    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        if (kind == 0) set_susp[ch] = 1'b1;
        else if (kind == 1) set_cmpl[ch] = 1'b1;
        else set_err[ch] = 1'b1;
        @(posedge clk); #1;
        set_susp = '0; set_cmpl = '0; set_err = '0;
    endtask

    task automatic expect_reg(input string tag, input logic [15:0] exp);
        logic [15:0] d; logic r;
        reg_rd(8'h20, d, r);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 reset value", 16'h0000);
        chk("R1 irq_any after reset", {15'd0, irq_any}, 16'h0000);
    endtask

    task automatic t_order;
        pulse(1, 9);
        expect_reg("R7 first pending ch9 / R4 TCMPL", 16'h0209);
        chk("R12 irq_any high", {15'd0, irq_any}, 16'h0001);
        pulse(2, 12);
        expect_reg("R8 higher ch12 keeps ch9", 16'h0209);
        pulse(0, 4);
        expect_reg("R7 lower ch4 takes over", 16'h0404);
    endtask

    task automatic t_w1c;
        reg_wr(8'h20, 16'h0204);
        expect_reg("R5 zero/absent bits leave SUSP", 16'h0404);
        reg_wr(8'h20, 16'h0404);
        expect_reg("R9 after clear ch4 -> ch9", 16'h0209);
        reg_wr(8'h20, 16'h0209);
        expect_reg("R9 after clear ch9 -> ch12 TERR", 16'h010C);
    endtask

    task automatic t_indirect;
        ch_pend[5] = 1'b1; ch_busy[5] = 1'b1; ch_ferr[5] = 1'b1;
        reg_wr(8'h20, 16'h0005);
        expect_reg("R11 select ch5 / R3 levels", 16'hE005);
        reg_wr(8'h20, 16'hE005);
        expect_reg("R3 write to level bits ignored", 16'hE005);
        reg_wr(8'h20, 16'h010C);
        expect_reg("R10 all cleared reads zero", 16'h0000);
        chk("R12 irq_any low when empty", {15'd0, irq_any}, 16'h0000);
        ch_pend[5] = 1'b0; ch_busy[5] = 1'b0; ch_ferr[5] = 1'b0;
    endtask

    task automatic t_multi_flag;
        pulse(0, 7); pulse(1, 7); pulse(2, 7);
        expect_reg("R2 R4 all three flags ch7", 16'h0707);
        reg_wr(8'h20, 16'h0207);
        expect_reg("R5 only TCMPL cleared", 16'h0507);
        reg_wr(8'h20, 16'h0507);
        expect_reg("R10 empty after ch7 cleared", 16'h0000);
    endtask

    task automatic t_set_wins;
        pulse(1, 2);
        expect_reg("R4 ch2 TCMPL", 16'h0202);
        @(negedge clk);
        bus_addr = 8'h20; bus_wdata = 16'h0202; bus_wr = 1'b1; set_cmpl[2] = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; set_cmpl = '0;
        expect_reg("R6 set beats clear", 16'h0202);
        reg_wr(8'h20, 16'h0202);
        expect_reg("R6 later clear works", 16'h0000);
    endtask

    task automatic t_simultaneous;
        @(negedge clk);
        set_err[11] = 1'b1; set_susp[6] = 1'b1; set_cmpl[14] = 1'b1;
        @(posedge clk); #1;
        set_susp = '0; set_cmpl = '0; set_err = '0;
        expect_reg("R7 lowest of simultaneous ch6", 16'h0406);
        reg_wr(8'h20, 16'h0406);
        expect_reg("R9 next lowest ch11", 16'h010B);
        reg_wr(8'h20, 16'h010B);
        expect_reg("R9 next lowest ch14", 16'h020E);
        reg_wr(8'h20, 16'h020E);
        expect_reg("R10 empty again", 16'h0000);
    endtask

    task automatic t_other_addr;
        logic [15:0] d; logic r;
        pulse(2, 3);
        reg_wr(8'h24, 16'h0103);
        reg_rd(8'h24, d, r);
        chk("R13 foreign read zero", d, 16'h0000);
        chk("R13 ready on read", {15'd0, r}, 16'h0001);
        expect_reg("R13 foreign write ignored", 16'h0103);
        reg_wr(8'h20, 16'h0103);
        expect_reg("R10 final empty", 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_order();
        t_w1c();
        t_indirect();
        t_multi_flag();
        t_set_wins();
        t_simultaneous();
        t_other_addr();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule